// File: doc/BRIEF.md
# Second-Order Cascaded Integrator-Comb Interpolator, Ratio 16

This block raises the sample rate of a signed baseband stream by a factor of sixteen. Words arrive on `in_data` with a one-cycle `in_valid` strobe, one strobe every sixteen core clocks. The core clock is the fast output rate. Two differencing stages run once per strobe. Each of them subtracts the previous slow word by adding its bitwise complement with a carry of one, and registers the result. A hold register then captures the second difference, and it is read unchanged on every fast clock of the slow period (no zero insertion). Two accumulators clocked on every core cycle integrate that held value twice.

All internal arithmetic is carried at the input width plus `ORDER*log2(RATE)` bits. For the defaults that is 16 + 8 = 24 bits. Two's-complement wrap in the intermediate stages is harmless because the true final sum always fits in that width. The output is the top 16 bits of the last accumulator. The steady-state gain of the chain is 256, so after truncation a constant input reappears unchanged at the output. A downstream modulator takes one output word on every core clock once `out_valid` has risen.

Top module: `cic_interp_x16`

## Requirements
- R1: After reset `out_data` is 0 and `out_valid` is 0.
- R2: A constant input value x, held for at least four slow periods, makes `out_data` equal x on every fast clock.
- R3: From an all-zero state, a word x strobed at rising edge E leaves `out_data` at 0 through edge E+3. After edge E+4, `out_data` equals the top 16 bits of the 24-bit value x, which is x shifted right arithmetically by 8.
- R4: For any input sequence, on every fast clock `out_data` equals bits 23..8 of A2. A2 is obtained as follows: D(n) = x(n) − 2·x(n−1) + x(n−2) over the strobed words. D(n) is held from two edges after its strobe. A1 accumulates the held value on every edge, and A2 accumulates A1 on every edge.
- R5: Inputs at both full-scale extremes (−32768 and +32767), alternating or held, produce outputs that match R4 with no overflow. A held −32768 settles to exactly −32768.
- R6: Once the input is constant and the chain has settled, `out_data` keeps the same value across all sixteen fast clocks of every slow period. The hold register changes only on the clock after the second differencing stage updates.
- R7: `out_valid` rises on the edge at which the first strobed word reaches the hold register, which is two edges after its strobe. It then stays high until reset.
- R8: After the first strobe, `in_valid` is high on exactly one clock in every sixteen. Under that cadence the output tracks R4 over long runs.
- R9: `in_data` is ignored whenever `in_valid` is low, including arbitrary values between strobes.
- R10: Asserting the asynchronous active-low reset mid-stream clears `out_data` and `out_valid` at once. A new stream started after reset behaves as from power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast core clock (output sample rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Slow-rate strobe, one clock in every sixteen |
| in_data | input | IN_W (16) | Signed baseband word, sampled when `in_valid` is high |
| out_valid | output | 1 | High from the first held sample until reset |
| out_data | output | OUT_W (16) | Signed interpolated word, top bits of the final accumulator |

## Verification
The embedded assertions cover several rules on every cycle. They check the strobe cadence of one pulse per sixteen clocks, and that the differencing registers stay quiet between strobes. They check that the hold register moves only after the second differencing stage fires, and that `out_valid` never falls. They also check that the last differencing stage fires exactly `ORDER` clocks after a strobe. The numerical behaviour needs the bench's scenarios: exact latency from zero state, DC gain of one, full-scale extremes without overflow, immunity to garbage between strobes, and recovery after a mid-stream reset. For these the bench compares every output word against an exact wide-integer reference.

// File: rtl/cic_interp_pkg.sv
package cic_interp_pkg;

    localparam int unsigned CIC_IN_W_DEF      = 16;
    localparam int unsigned CIC_OUT_W_DEF     = 16;
    localparam int unsigned CIC_RATE_LOG2_DEF = 4;
    localparam int unsigned CIC_ORDER_DEF     = 2;

    // Bits of growth needed so the final accumulator never overflows.
    function automatic int unsigned cic_growth(input int unsigned order,
                                               input int unsigned rate_log2);
        return order * rate_log2;
    endfunction

endpackage

// File: rtl/cic_comb_stage.sv
module cic_comb_stage #(
    parameter int unsigned W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb_i,
    input  logic signed [W-1:0] dat_i,
    output logic                stb_o,
    output logic signed [W-1:0] dat_o
);

    localparam logic signed [W-1:0] CARRY_ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic                stb;
        logic signed [W-1:0] prev;
        logic signed [W-1:0] diff;
    } comb_state_t;

    comb_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.stb = stb_i;
        if (stb_i) begin
            // current + inverted previous + carry-in = exact difference
            s_d.diff = dat_i + (~s_q.prev) + CARRY_ONE;
            s_d.prev = dat_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stb_o = s_q.stb;
    assign dat_o = s_q.diff;

    // R9: no strobe, no change in the difference register
    assert_comb_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(dat_o));

endmodule

// File: rtl/cic_hold_stage.sv
module cic_hold_stage #(
    parameter int unsigned W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic signed [W-1:0] dat_i,
    output logic signed [W-1:0] dat_o
);

    typedef struct packed {
        logic signed [W-1:0] val;
    } hold_state_t;

    hold_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.val = dat_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dat_o = s_q.val;

    // R6: held value is read non-destructively between loads
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(dat_o));

endmodule

// File: rtl/cic_integ_stage.sv
module cic_integ_stage #(
    parameter int unsigned W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] dat_i,
    output logic signed [W-1:0] dat_o
);

    typedef struct packed {
        logic signed [W-1:0] acc;
    } integ_state_t;

    integ_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.acc = s_q.acc + dat_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dat_o = s_q.acc;

    // R4: a zero input leaves the accumulator unchanged
    assert_integ_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_i == '0) |=> $stable(dat_o));

endmodule

// File: rtl/cic_interp_x16.sv
module cic_interp_x16
    import cic_interp_pkg::*;
#(
    parameter int unsigned IN_W      = CIC_IN_W_DEF,
    parameter int unsigned OUT_W     = CIC_OUT_W_DEF,
    parameter int unsigned RATE_LOG2 = CIC_RATE_LOG2_DEF,
    parameter int unsigned ORDER     = CIC_ORDER_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);

    localparam int unsigned GROW = cic_growth(ORDER, RATE_LOG2);
    localparam int unsigned W    = IN_W + GROW;

    // slow-rate differencing chain
    logic                cstb [ORDER+1];
    logic signed [W-1:0] cdat [ORDER+1];

    assign cstb[0] = in_valid;
    assign cdat[0] = {{GROW{in_data[IN_W-1]}}, in_data};

    for (genvar g = 0; g < ORDER; g++) begin : g_comb
        cic_comb_stage #(.W(W)) u_comb (
            .clk   (clk),
            .rst_n (rst_n),
            .stb_i (cstb[g]),
            .dat_i (cdat[g]),
            .stb_o (cstb[g+1]),
            .dat_o (cdat[g+1])
        );
    end

    // rate change: hold the last difference for every fast read
    logic signed [W-1:0] idat [ORDER+1];

    cic_hold_stage #(.W(W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cstb[ORDER]),
        .dat_i  (cdat[ORDER]),
        .dat_o  (idat[0])
    );

    // fast-rate accumulator chain
    for (genvar g = 0; g < ORDER; g++) begin : g_integ
        cic_integ_stage #(.W(W)) u_integ (
            .clk   (clk),
            .rst_n (rst_n),
            .dat_i (idat[g]),
            .dat_o (idat[g+1])
        );
    end

    // output qualifier and strobe-cadence tracking
    typedef struct packed {
        logic [RATE_LOG2-1:0] gap;
        logic                 seen;
        logic                 ovld;
    } mon_state_t;

    mon_state_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (in_valid) begin
            m_d.gap  = '0;
            m_d.seen = 1'b1;
        end else if (m_q.seen) begin
            m_d.gap = m_q.gap + 1'b1;
        end
        m_d.ovld = m_q.ovld | cstb[ORDER];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign out_valid = m_q.ovld;
    assign out_data  = idat[ORDER][W-1 -: OUT_W];

    // R8: strobes are exactly one period of 2**RATE_LOG2 clocks apart
    assert_strobe_late_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.seen && in_valid) |-> (m_q.gap == '1));
    assert_strobe_missing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.seen && m_q.gap == '1) |-> in_valid);

    // R7: output qualifier never drops once raised
    assert_valid_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);

    // R3: the last differencing stage fires ORDER clocks after a strobe
    assert_comb_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cstb[ORDER] |-> $past(in_valid, ORDER));

endmodule

// File: tb/cic_interp_x16_tb_top.sv
module cic_interp_x16_tb_top;

    logic               clk      = 1'b0;
    logic               rst_n    = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_data  = '0;
    logic               out_valid;
    logic signed [15:0] out_data;

    always #5 clk = ~clk;

    cic_interp_x16 dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag   = "R1";
    logic  done  = 1'b0;
    logic signed [15:0] seen_out;
    logic               seen_vld;

    // exact wide-integer reference
    longint m_x1 = 0, m_x2 = 0, m_p0d = 0, m_p1d = 0, m_hold = 0, m_a1 = 0, m_a2 = 0;
    logic   m_p0v = 1'b0, m_p1v = 1'b0, m_v = 1'b0;

    always @(posedge clk or negedge rst_n) begin : ref_model
        longint na2, na1, nh, xv;
        logic   nv;
        if (!rst_n) begin
            m_x1 = 0; m_x2 = 0; m_p0d = 0; m_p1d = 0;
            m_hold = 0; m_a1 = 0; m_a2 = 0;
            m_p0v = 1'b0; m_p1v = 1'b0; m_v = 1'b0;
        end else begin
            na2 = m_a2 + m_a1;
            na1 = m_a1 + m_hold;
            nh  = m_p1v ? m_p1d : m_hold;
            nv  = m_v | m_p1v;
            m_p1v = m_p0v;
            m_p1d = m_p0d;
            m_p0v = in_valid;
            if (in_valid) begin
                xv    = longint'(in_data);
                m_p0d = xv - 2 * m_x1 + m_x2;
                m_x2  = m_x1;
                m_x1  = xv;
            end
            m_a2 = na2; m_a1 = na1; m_hold = nh; m_v = nv;
        end
    end

    function automatic longint ref_out();
        logic signed [15:0] e;
        e = 16'(m_a2 >>> 8);
        return longint'(e);
    endfunction

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one fast clock: compare, then drive the next input
    task automatic tick(input logic stb, input logic signed [15:0] v);
        @(negedge clk);
        seen_out = out_data;
        seen_vld = out_valid;
        check(tag, "out_data", longint'(out_data), ref_out());
        check(tag, "out_valid", longint'(out_valid), longint'(m_v));
        in_valid = stb;
        in_data  = stb ? v : 16'($urandom);
    endtask

    task automatic slow(input logic signed [15:0] v);
        tick(1'b1, v);
        repeat (15) tick(1'b0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        #1;
        check("R10", "out_data in reset", longint'(out_data), 0);
        check("R10", "out_valid in reset", longint'(out_valid), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "out_data after reset", longint'(out_data), 0);
        check("R1", "out_valid after reset", longint'(out_valid), 0);

        // R3 / R7 latency of a single word from zero state
        tag = "R3";
        tick(1'b0, '0);
        tick(1'b1, 16'sd16384);
        for (int k = 1; k <= 5; k++) begin
            tick(1'b0, '0);
            if (k < 5) check("R3", "out_data before latency", longint'(seen_out), 0);
            else       check("R3", "out_data at latency", longint'(seen_out), 64);
            if (k < 3) check("R7", "out_valid early", longint'(seen_vld), 0);
            else       check("R7", "out_valid raised", longint'(seen_vld), 1);
        end
        repeat (10) tick(1'b0, '0);

        // R2 / R6 DC gain and flat output within a period
        tag = "R2";
        repeat (4) slow(16'sd16384);
        tag = "R6";
        for (int k = 0; k < 16; k++) begin
            tick(k == 0, 16'sd16384);
            check("R6", "flat DC output", longint'(seen_out), 16384);
        end

        // R5 full-scale extremes
        tag = "R5";
        for (int k = 0; k < 8; k++) slow((k % 2 == 0) ? -16'sd32768 : 16'sd32767);
        repeat (4) slow(-16'sd32768);
        tick(1'b1, -16'sd32768);
        check("R5", "held negative full scale", longint'(seen_out), -32768);
        repeat (15) tick(1'b0, '0);

        // R4 varied waveform
        tag = "R4";
        for (int k = 0; k < 24; k++) slow(16'((k * k * 37) % 20000 - 10000));

        // R9 garbage between strobes (always driven) on a held value
        tag = "R9";
        repeat (5) slow(16'sd1234);
        tick(1'b1, 16'sd1234);
        check("R9", "value unaffected by garbage", longint'(seen_out), 1234);
        repeat (15) tick(1'b0, '0);

        // R8 long run under the required cadence
        tag = "R8";
        for (int k = 0; k < 40; k++) slow(16'((k * 5003) % 60000 - 30000));

        // R10 mid-stream reset and restart
        do_reset();
        tag = "R10";
        tick(1'b0, '0);
        check("R10", "out_valid after restart", longint'(seen_vld), 0);
        repeat (6) slow(16'(-7777));
        tick(1'b1, 16'(-7777));
        check("R10", "restart settles", longint'(seen_out), -7777);
        repeat (15) tick(1'b0, '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule